// File: doc/BRIEF.md
# Dual Prescaled Reference Timer

This block holds two 16-bit up-counters behind a small word-wide register port. Each counter's tick comes from a chain of three dividers in series. The first is an optional fixed divide-by-16 stage. The second is an 8-bit primary divider and the third is an 8-bit secondary divider. When a counter reaches its programmed reference value, the block latches a sticky match flag. It can either wrap the counter to zero or let it run on, and it can raise a shared interrupt line.

One configuration byte is shared by both timers. It carries a stop bit and a reset bit for each timer, so software can hold, preset and release either timer without disturbing the other. A typical sequence is:

1. Set both of the timer's bits.
2. Program the mode, reference and primary divider registers.
3. Clear pending flags.
4. Release the reset bit.
5. Optionally preset the counter.
6. Clear the stop bit to start counting.

Top module: `gtimer_pair`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Address map (4-bit word address): 0 is the configuration byte, read back in bits [7:0]. Timer t (t = 0 or 1) sits at base 8·t, with mode at +1, reference at +2, counter at +3, event at +4 and primary divider at +5. A read issued with `rdEn` returns its data on `rdData` with `rdValid` high one clock later.
- R3: Mode bits [2:1] pick the tick source. 1 selects the system clock, 2 selects the system clock divided by 16, and 0 leaves the counter stalled.
- R4: With primary divider value p (bits [7:0] of the divider register) and secondary value s (mode bits [15:8]), one counter tick occurs every (p+1)·(s+1) enabled clocks. The slow source multiplies this by 16.
- R5: With mode bit 3 set, a tick taken while the counter equals the reference returns the counter to zero. With bit 3 clear, the counter keeps incrementing past the reference.
- R6: Event bit 1 is set by a tick taken while the counter equals the reference, and it stays set until cleared. Writing the event register clears exactly the bits written as 1.
- R7: `irq` is high whenever some timer has event bit 1 set while its mode bit 4 is set.
- R8: In the configuration byte, timer 0 uses bit 1 as stop and bit 0 as reset, and timer 1 uses bit 5 as stop and bit 4 as reset. A timer counts only while its stop bit is clear; while it is stopped, its counter keeps its value.
- R9: While a timer's reset bit is set, its counter and all three divider stages are held at zero, and host writes to its counter have no effect.
- R10: The host can write the counter. A free-running counter wraps from 0xFFFF to 0x0000.
- R11: The two timers are independent. Running or reprogramming one leaves the other's counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Write word address |
| wrData | input | 16 | Write data |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | 4 | Read word address |
| rdData | output | 16 | Read data, registered |
| rdValid | output | 1 | High the cycle after a read strobe |
| irq | output | 1 | Combined reference-match interrupt |

## Verification
Each timer is run for a fixed number of enabled clocks. The counter and event flag are then read back and compared with a tick-by-tick model built from the requirements. The settings exercised are:

- Plain system-clock ticking with a wrapping reference, which exposes off-by-one errors in the match and wrap logic.
- The same reference in free-run mode, which distinguishes restart from run-on.
- A reference that is never reached, which shows the flag is not set spuriously.
- Primary-only, secondary-only and slow-go chains, each of which isolates one stage of the divide product.
- The stalled source.

Further sequences cover a preset counter wrapping through 0xFFFF and masked event clears with the interrupt enable toggled. They also check that the reset bit zeroes a stopped counter and that one timer's activity leaves the other's count untouched.

// File: rtl/gtimer_pkg.sv
package gtimer_pkg;
  localparam int CNT_W    = 16;
  localparam int PS_W     = 8;
  localparam int SLOW_DIV = 16;
  localparam int SLOW_W   = $clog2(SLOW_DIV);
  localparam int N_TMR    = 2;
  localparam int ADDR_W   = 4;
  localparam int MATCH_BIT = 1;

  // word-offset of each per-timer field inside a timer's address window
  localparam logic [2:0] F_MODE = 3'd1;
  localparam logic [2:0] F_REF  = 3'd2;
  localparam logic [2:0] F_CNT  = 3'd3;
  localparam logic [2:0] F_EVT  = 3'd4;
  localparam logic [2:0] F_PSR  = 3'd5;

  typedef enum logic [1:0] {
    SRC_CASCADE = 2'd0,
    SRC_SYS     = 2'd1,
    SRC_SLOW    = 2'd2,
    SRC_RSVD    = 2'd3
  } clkSrc_e;

  // strobes the control hands to one timer's datapath each cycle
  typedef struct packed {
    logic             run;
    logic             hold;
    logic             cntWr;
    logic [CNT_W-1:0] cntVal;
    logic [CNT_W-1:0] evtClr;
  } tmrStrobe_t;

  // static programming of one timer
  typedef struct packed {
    clkSrc_e          src;
    logic             restart;
    logic             intEn;
    logic [PS_W-1:0]  priDiv;
    logic [PS_W-1:0]  secDiv;
    logic [CNT_W-1:0] refVal;
  } tmrSetup_t;
endpackage

// File: rtl/gtimer_datapath.sv
module gtimer_datapath
  import gtimer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  tmrSetup_t        setup,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] evt
);
  logic [SLOW_W-1:0] slowCnt;
  logic [PS_W-1:0]   priCnt;
  logic [PS_W-1:0]   secCnt;
  logic srcLive, slowDone, stage1, priDone, stage2, secDone, tick, match;

  always_comb begin
    srcLive  = strobe.run && (setup.src == SRC_SYS || setup.src == SRC_SLOW);
    slowDone = (setup.src != SRC_SLOW) || (slowCnt == SLOW_W'(SLOW_DIV - 1));
    stage1   = srcLive && slowDone;
    priDone  = priCnt >= setup.priDiv;
    stage2   = stage1 && priDone;
    secDone  = secCnt >= setup.secDiv;
    tick     = stage2 && secDone;
    match    = tick && !strobe.cntWr && (count == setup.refVal);
  end

  // divider chain: each stage advances only when the one before wraps
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slowCnt <= '0;
      priCnt  <= '0;
      secCnt  <= '0;
    end else if (strobe.hold) begin
      slowCnt <= '0;
      priCnt  <= '0;
      secCnt  <= '0;
    end else begin
      if (srcLive && setup.src == SRC_SLOW) slowCnt <= slowCnt + 1'b1;
      if (stage1) priCnt <= priDone ? '0 : priCnt + 1'b1;
      if (stage2) secCnt <= secDone ? '0 : secCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              count <= '0;
    else if (strobe.hold)   count <= '0;
    else if (strobe.cntWr)  count <= strobe.cntVal;
    else if (tick)          count <= (match && setup.restart) ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evt <= '0;
    else       evt <= (evt & ~strobe.evtClr) | (match ? CNT_W'(1) << MATCH_BIT : '0);
  end

  a_r9_hold_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hold |=> (count == '0));
  a_r8_stop_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.hold && !strobe.cntWr) |=> $stable(count));
  a_r6_evt_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (evt[MATCH_BIT] && !strobe.evtClr[MATCH_BIT]) |=> evt[MATCH_BIT]);
  a_r10_step: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.hold && !strobe.cntWr) |=>
      (count == $past(count) || count == $past(count) + 16'd1 || count == '0));
endmodule

// File: rtl/gtimer_ctrl.sv
module gtimer_ctrl
  import gtimer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic              rdValid,
  input  logic [CNT_W-1:0]  cntIn  [N_TMR],
  input  logic [CNT_W-1:0]  evtIn  [N_TMR],
  output tmrStrobe_t        strobe [N_TMR],
  output tmrSetup_t         setup  [N_TMR],
  output logic              irq
);
  logic [7:0]       cfgByte;
  logic [CNT_W-1:0] modeReg [N_TMR];
  logic [CNT_W-1:0] refReg  [N_TMR];
  logic [PS_W-1:0]  psrReg  [N_TMR];

  // bit positions inside the shared configuration byte
  function automatic int stopPos(input int t);
    return (t % 2 == 1) ? 5 : 1;
  endfunction
  function automatic int rstPos(input int t);
    return (t % 2 == 1) ? 4 : 0;
  endfunction

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int t, input logic [2:0] f);
    return (a[ADDR_W-1] == 1'(t)) && (a[2:0] == f);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgByte <= '0;
      for (int t = 0; t < N_TMR; t++) begin
        modeReg[t] <= '0;
        refReg[t]  <= '0;
        psrReg[t]  <= '0;
      end
    end else if (wrEn) begin
      if (wrAddr == '0) cfgByte <= wrData[7:0];
      for (int t = 0; t < N_TMR; t++) begin
        if (hit(wrAddr, t, F_MODE)) modeReg[t] <= wrData;
        if (hit(wrAddr, t, F_REF))  refReg[t]  <= wrData;
        if (hit(wrAddr, t, F_PSR))  psrReg[t]  <= wrData[PS_W-1:0];
      end
    end
  end

  always_comb begin
    irq = 1'b0;
    for (int t = 0; t < N_TMR; t++) begin
      strobe[t].hold   = cfgByte[rstPos(t)];
      strobe[t].run    = !cfgByte[stopPos(t)] && !cfgByte[rstPos(t)];
      strobe[t].cntWr  = wrEn && hit(wrAddr, t, F_CNT);
      strobe[t].cntVal = wrData;
      strobe[t].evtClr = (wrEn && hit(wrAddr, t, F_EVT)) ? wrData : '0;
      setup[t].src     = clkSrc_e'(modeReg[t][2:1]);
      setup[t].restart = modeReg[t][3];
      setup[t].intEn   = modeReg[t][4];
      setup[t].secDiv  = modeReg[t][15:8];
      setup[t].priDiv  = psrReg[t];
      setup[t].refVal  = refReg[t];
      irq = irq | (evtIn[t][MATCH_BIT] && modeReg[t][4]);
    end
  end

  logic [CNT_W-1:0] rdMux;
  always_comb begin
    rdMux = '0;
    if (rdAddr == '0) rdMux = {{(CNT_W-8){1'b0}}, cfgByte};
    for (int t = 0; t < N_TMR; t++) begin
      if (hit(rdAddr, t, F_MODE)) rdMux = modeReg[t];
      if (hit(rdAddr, t, F_REF))  rdMux = refReg[t];
      if (hit(rdAddr, t, F_CNT))  rdMux = cntIn[t];
      if (hit(rdAddr, t, F_EVT))  rdMux = evtIn[t];
      if (hit(rdAddr, t, F_PSR))  rdMux = {{(CNT_W-PS_W){1'b0}}, psrReg[t]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) rdData <= rdMux;
    end
  end

  a_r8_cfg_decode: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == '0) |=>
      (strobe[1].run == !($past(wrData[5]) || $past(wrData[4])) &&
       strobe[0].hold == $past(wrData[0])));
  a_r2_read_valid: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);
endmodule

// File: rtl/gtimer_pair.sv
module gtimer_pair
  import gtimer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic              rdValid,
  output logic              irq
);
  tmrStrobe_t       strobe [N_TMR];
  tmrSetup_t        setup  [N_TMR];
  logic [CNT_W-1:0] cntBus [N_TMR];
  logic [CNT_W-1:0] evtBus [N_TMR];

  gtimer_ctrl ctrl (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid),
    .cntIn(cntBus), .evtIn(evtBus),
    .strobe(strobe), .setup(setup), .irq(irq)
  );

  for (genvar t = 0; t < N_TMR; t++) begin : gTmr
    gtimer_datapath dp (
      .clk(clk), .rstN(rstN),
      .strobe(strobe[t]), .setup(setup[t]),
      .count(cntBus[t]), .evt(evtBus[t])
    );
  end
endmodule

// File: tb/gtimer_pair_test.sv
module gtimer_pair_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [3:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        rdValid;
  logic        irq;

  int errors = 0;
  int checks = 0;
  logic [7:0] cfgShadow = '0;
  logic [15:0] expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  gtimer_pair uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid), .irq(irq)
  );

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected read data actual=%h expected=none", rdData);
      end else begin
        logic [15:0] e;
        string tg;
        e = expQ.pop_front();
        tg = tagQ.pop_front();
        if (rdData !== e) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", tg, rdData, e);
        end
      end
    end
  end

  task automatic regWrite(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic expectRead(input logic [3:0] a, input logic [15:0] e, input string tg);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = a;
    expQ.push_back(e); tagQ.push_back(tg);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic checkIrq(input logic e, input string tg);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", tg, irq, e);
    end
  endtask

  task automatic setCfg(input int t, input logic stop, input logic hold);
    if (t == 0) begin cfgShadow[1] = stop; cfgShadow[0] = hold; end
    else        begin cfgShadow[5] = stop; cfgShadow[4] = hold; end
    regWrite(4'd0, {8'h00, cfgShadow});
  endtask

  // tick-by-tick reference model from R5, R6, R10
  task automatic model(input int n, input logic [15:0] pre, input logic [15:0] refV,
                       input logic restart, output logic [15:0] c, output logic ev);
    c = pre; ev = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (c == refV) begin
        ev = 1'b1;
        c = restart ? 16'h0000 : c + 16'h1;
      end else c = c + 16'h1;
    end
  endtask

  task automatic scenario(input int t, input logic [1:0] src, input logic [7:0] psr,
                          input logic [7:0] sps, input logic [15:0] refV, input logic restart,
                          input logic ie, input logic [15:0] pre, input int w, input string tg);
    logic [3:0] base;
    int div, n;
    logic [15:0] c;
    logic ev;
    base = (t == 1) ? 4'd8 : 4'd0;
    setCfg(t, 1'b1, 1'b1);
    regWrite(base + 4'd1, {sps, 3'b000, ie, restart, src, 1'b0});
    regWrite(base + 4'd2, refV);
    regWrite(base + 4'd5, {8'h00, psr});
    regWrite(4'd4, 16'hFFFF);
    regWrite(4'd12, 16'hFFFF);
    setCfg(t, 1'b1, 1'b0);
    if (pre != 16'h0) regWrite(base + 4'd3, pre);
    setCfg(t, 1'b0, 1'b0);
    repeat (w) @(negedge clk);
    setCfg(t, 1'b1, 1'b0);
    // the stop write lands w+2 edges after the start write
    div = (int'(psr) + 1) * (int'(sps) + 1) * ((src == 2'd2) ? 16 : 1);
    n = (src == 2'd1 || src == 2'd2) ? (w + 2) / div : 0;
    model(n, pre, refV, restart, c, ev);
    expectRead(base + 4'd3, c, {tg, " count"});
    expectRead(base + 4'd4, ev ? 16'h0002 : 16'h0000, {tg, " event"});
    checkIrq(ev && ie, {tg, " R7"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state, R2 address map
    for (int a = 0; a < 14; a++) expectRead(4'(a), 16'h0000, "R1 reset value");
    checkIrq(1'b0, "R1 reset irq");

    scenario(0, 2'd1, 8'd0, 8'd0, 16'd5,   1'b1, 1'b1, 16'h0, 20,  "R5 restart wrap");
    scenario(0, 2'd1, 8'd0, 8'd0, 16'd5,   1'b0, 1'b1, 16'h0, 20,  "R5 free run");
    scenario(0, 2'd1, 8'd0, 8'd0, 16'd100, 1'b1, 1'b1, 16'h0, 20,  "R6 no match");
    scenario(0, 2'd1, 8'd3, 8'd0, 16'd3,   1'b1, 1'b1, 16'h0, 40,  "R4 primary");
    scenario(0, 2'd1, 8'd0, 8'd4, 16'd7,   1'b0, 1'b1, 16'h0, 40,  "R4 secondary");
    scenario(0, 2'd2, 8'd1, 8'd2, 16'd2,   1'b1, 1'b1, 16'h0, 400, "R3 slow source");
    scenario(1, 2'd1, 8'd0, 8'd0, 16'd2,   1'b1, 1'b0, 16'h0, 10,  "R8 timer1 ie off");

    // R11: timer 0 stopped since the slow scenario, its count must still be 1
    expectRead(4'd3, 16'h0001, "R11 timer0 untouched");
    // R8: stopped counter keeps its value over time
    repeat (30) @(negedge clk);
    expectRead(4'd11, 16'h0000, "R8 timer1 frozen");

    // R7/R6: enable timer1 interrupt over its pending flag, then masked clears
    regWrite(4'd9, 16'h001A);
    checkIrq(1'b1, "R7 enable raises irq");
    regWrite(4'd12, 16'hFFFD);
    expectRead(4'd12, 16'h0002, "R6 masked clear keeps flag");
    regWrite(4'd12, 16'h0002);
    expectRead(4'd12, 16'h0000, "R6 w1c clears flag");
    checkIrq(1'b0, "R7 irq drops after clear");

    // R9: reset bit zeroes a stopped counter and blocks host writes
    setCfg(0, 1'b1, 1'b1);
    expectRead(4'd3, 16'h0000, "R9 reset bit clears count");
    regWrite(4'd3, 16'h1234);
    expectRead(4'd3, 16'h0000, "R9 write ignored while held");

    scenario(1, 2'd1, 8'd0, 8'd0, 16'h0010, 1'b0, 1'b1, 16'hFFFE, 2, "R10 preset wrap");
    scenario(0, 2'd0, 8'd0, 8'd0, 16'd1,    1'b1, 1'b1, 16'h0,    30, "R3 cascade stalls");

    repeat (4) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R2 missing reads actual=%0d expected=0", expQ.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule